// File: doc/BRIEF.md
# Bidirectional Logarithmic Barrel Shifter

This block shifts a 32-bit word by 0 to 31 positions in one combinational pass. It has no clock and no registers. The output follows the data word, the 5-bit amount, a direction select and a fill-mode select. Three operations are offered: logical left, logical right and arithmetic right. The block suits an ALU-style datapath in which a shift result must be ready in the same cycle as its operands.

Internally there is a single right-shifting cascade of five conditional stages. The stage steered by amount bit 4 comes first and the stage steered by bit 0 comes last. Each stage moves its word right by 2^k positions when its amount bit is set, and otherwise passes the word through. A left shift reverses the bit order of the operand before the cascade, runs the cascade with zero fill, and reverses the result again. Every mode therefore shares the same mux chain.

Top module: `barrel_shifter`

## Requirements
- R1: With an amount of zero, `shf_out` equals `shf_in` in every combination of `dir_left` and `arith`.
- R2: With `dir_left`=0 and `arith`=0, `shf_out` is `shf_in` moved toward bit 0 by `shf_amt` places, and the vacated top `shf_amt` bits are 0.
- R3: With `dir_left`=0 and `arith`=1, the vacated top `shf_amt` bits take the value of `shf_in[31]`, and the remaining bits match the logical right shift.
- R4: With `dir_left`=1, `shf_out` is `shf_in` moved toward bit 31 by `shf_amt` places, and the vacated low `shf_amt` bits are 0.
- R5: `arith` has no effect when `dir_left`=1: both values of `arith` give the same output for the same word and amount.
- R6: Every amount from 0 to 31 is honoured, including the maximum of 31. At 31 a logical shift keeps one bit and an arithmetic right shift yields all copies of the sign bit.
- R7: The path holds no state. `shf_out` depends only on the present inputs and settles within the same cycle in which they change.
- R8: Each cascade stage k either passes its word or shifts it right by 2^k places, as amount bit k decides. Under zero fill, no stage raises the number of set bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| shf_in | input | 32 | Data word to shift |
| shf_amt | input | 5 | Shift distance, 0 to 31 |
| dir_left | input | 1 | 1 = toward bit 31, 0 = toward bit 0 |
| arith | input | 1 | 1 = sign fill on right shifts, 0 = zero fill |
| shf_out | output | 32 | Shifted word |

## Verification
Immediate assertions check every input change. They cover the identity at amount zero, the vacated-bit fill for each mode, sign retention on arithmetic right shifts, and the fact that no stage adds set bits under zero fill. The exact bit pattern of every result is shown only by the bench scenarios. The same scenarios show that `arith` is ignored on left shifts and that the output tracks a new input within one cycle. The bench compares each result against the language's own shift operators over directed corners and a long pseudo-random sweep.

// File: rtl/shf_pkg.sv
package shf_pkg;
  typedef enum logic {SHF_RIGHT = 1'b0, SHF_LEFT = 1'b1} shf_dir_e;
  typedef enum logic {FILL_ZERO = 1'b0, FILL_SIGN = 1'b1} shf_fill_e;
endpackage

// File: rtl/shf_precond.sv
module shf_precond #(
  parameter int W = 32
) (
  input  logic [W-1:0] din,
  input  logic         dir_left,
  input  logic         arith,
  output logic [W-1:0] word,
  output logic         fill
);
  import shf_pkg::*;

  function automatic logic [W-1:0] bit_reverse(input logic [W-1:0] v);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = v[W-1-i];
    return r;
  endfunction

  function automatic logic pick_fill(input logic left, input logic ar, input logic msb);
    shf_fill_e mode;
    mode = (!left && ar) ? FILL_SIGN : FILL_ZERO;
    return (mode == FILL_SIGN) ? msb : 1'b0;
  endfunction

  always_comb begin
    word = (shf_dir_e'(dir_left) == SHF_LEFT) ? bit_reverse(din) : din;
    fill = pick_fill(dir_left, arith, din[W-1]);
  end

  // left shifts never use sign fill
  always_comb begin
    if (dir_left) AST_LEFT_ZERO_FILL: assert (fill == 1'b0) else $error("left shift got sign fill"); // R5
  end
endmodule

// File: rtl/shf_stage.sv
module shf_stage #(
  parameter int W     = 32,
  parameter int SHIFT = 1
) (
  input  logic [W-1:0] x,
  input  logic         en,
  input  logic         fill,
  output logic [W-1:0] y
);
  localparam logic [W-1:0] FILL_MASK = ~({W{1'b1}} >> SHIFT);

  function automatic logic [W-1:0] step(input logic [W-1:0] v, input logic f);
    return (v >> SHIFT) | (f ? FILL_MASK : '0);
  endfunction

  always_comb y = en ? step(x, fill) : x;
endmodule

// File: rtl/shf_cascade.sv
module shf_cascade #(
  parameter int W  = 32,
  parameter int AW = 5
) (
  input  logic [W-1:0]  word_in,
  input  logic [AW-1:0] amt,
  input  logic          fill,
  output logic [W-1:0]  word_out
);
  logic [W-1:0] chain [AW+1];

  assign chain[0] = word_in;

  // stage i is steered by amount bit AW-1-i: the largest step comes first
  for (genvar i = 0; i < AW; i++) begin : g_stage
    localparam int K = AW - 1 - i;
    shf_stage #(.W(W), .SHIFT(1 << K)) u_stage (
      .x   (chain[i]),
      .en  (amt[K]),
      .fill(fill),
      .y   (chain[i+1])
    );
    always_comb begin
      if (!fill) AST_STAGE_NO_NEW_ONES: assert ($countones(chain[i+1]) <= $countones(chain[i]))
        else $error("stage %0d added set bits", K); // R8
      if (!amt[K]) AST_STAGE_IDLE_PASS: assert (chain[i+1] == chain[i])
        else $error("idle stage %0d changed word", K); // R8
    end
  end

  assign word_out = chain[AW];
endmodule

// File: rtl/shf_postcond.sv
module shf_postcond #(
  parameter int W = 32
) (
  input  logic [W-1:0] word,
  input  logic         dir_left,
  output logic [W-1:0] dout
);
  function automatic logic [W-1:0] bit_reverse(input logic [W-1:0] v);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = v[W-1-i];
    return r;
  endfunction

  always_comb dout = dir_left ? bit_reverse(word) : word;
endmodule

// File: rtl/barrel_shifter.sv
module barrel_shifter #(
  parameter  int DATA_W = 32,
  localparam int AMT_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] shf_in,
  input  logic [AMT_W-1:0]  shf_amt,
  input  logic              dir_left,
  input  logic              arith,
  output logic [DATA_W-1:0] shf_out
);
  logic [DATA_W-1:0] pre_word;
  logic              pre_fill;
  logic [DATA_W-1:0] core_word;
  logic [DATA_W-1:0] low_mask;
  logic [DATA_W-1:0] high_mask;

  shf_precond #(.W(DATA_W)) u_pre (
    .din     (shf_in),
    .dir_left(dir_left),
    .arith   (arith),
    .word    (pre_word),
    .fill    (pre_fill)
  );

  shf_cascade #(.W(DATA_W), .AW(AMT_W)) u_core (
    .word_in (pre_word),
    .amt     (shf_amt),
    .fill    (pre_fill),
    .word_out(core_word)
  );

  shf_postcond #(.W(DATA_W)) u_post (
    .word    (core_word),
    .dir_left(dir_left),
    .dout    (shf_out)
  );

  // masks of the vacated positions, used by the checks below
  assign low_mask  = ~({DATA_W{1'b1}} << shf_amt);
  assign high_mask = ~({DATA_W{1'b1}} >> shf_amt);

  always_comb begin
    if (shf_amt == '0) AST_ZERO_AMT_PASS: assert (shf_out == shf_in) else $error("amount 0 altered word"); // R1
    if (dir_left) AST_LEFT_LOW_ZERO: assert ((shf_out & low_mask) == '0) else $error("left fill not zero"); // R4
    if (!dir_left && !arith) AST_LRIGHT_HIGH_ZERO: assert ((shf_out & high_mask) == '0) else $error("right fill not zero"); // R2
    if (!dir_left && arith) AST_ARIGHT_SIGN_FILL: assert ((shf_out & high_mask) == (shf_in[DATA_W-1] ? high_mask : '0))
      else $error("sign fill wrong"); // R3
    if (!dir_left && arith) AST_ARIGHT_MSB_KEPT: assert (shf_out[DATA_W-1] == shf_in[DATA_W-1]) else $error("sign lost"); // R3
  end
endmodule

// File: tb/tb_barrel_shifter.sv
module tb_barrel_shifter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] shf_in = '0;
  logic [4:0]  shf_amt = '0;
  logic        dir_left = 1'b0;
  logic        arith = 1'b0;
  logic [31:0] shf_out;

  int total = 0;
  int bad = 0;
  bit done = 0;

  typedef struct {
    logic [31:0] exp;
    string       req;
  } item_t;
  item_t sb_q[$];

  barrel_shifter dut (
    .shf_in  (shf_in),
    .shf_amt (shf_amt),
    .dir_left(dir_left),
    .arith   (arith),
    .shf_out (shf_out)
  );

  always #2 clk = ~clk;

  function automatic logic [31:0] model(input logic [31:0] d, input logic [4:0] a,
                                        input logic l, input logic ar);
    if (l) return d << a;
    if (ar) return 32'($signed(d) >>> a);
    return d >> a;
  endfunction

  // driver: applies inputs at the falling edge and queues the expected result
  task automatic drive(input logic [31:0] d, input logic [4:0] a, input logic l,
                       input logic ar, input string req);
    item_t it;
    @(negedge clk);
    shf_in = d; shf_amt = a; dir_left = l; arith = ar;
    it.exp = model(d, a, l, ar);
    it.req = req;
    sb_q.push_back(it);
  endtask

  // monitor: compares at the next rising edge, half a cycle after the drive
  initial begin
    forever begin
      @(posedge clk);
      if (!rst && sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        total++;
        if (shf_out !== it.exp) begin
          bad++;
          $display("FAIL %s: got %h expected %h (in=%h amt=%0d left=%0b arith=%0b)",
                   it.req, shf_out, it.exp, shf_in, shf_amt, dir_left, arith);
        end
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    repeat (3) @(posedge clk);
    // reset state: all-zero inputs give all-zero output
    @(negedge clk);
    rst = 1'b0;
    total++;
    if (shf_out !== 32'h0) begin
      bad++;
      $display("FAIL R7 reset: got %h expected %h", shf_out, 32'h0);
    end
    // R1: amount zero in all four modes
    for (int m = 0; m < 4; m++) drive(32'hA5C3_0F81, 5'd0, m[1], m[0], "R1");
    // R2: logical right
    drive(32'hF000_0000, 5'd4, 1'b0, 1'b0, "R2");
    drive(32'h8000_0001, 5'd1, 1'b0, 1'b0, "R2");
    drive(32'hFFFF_FFFF, 5'd16, 1'b0, 1'b0, "R2");
    // R3: arithmetic right, negative and positive
    drive(32'h8000_0000, 5'd4, 1'b0, 1'b1, "R3");
    drive(32'h7FFF_FFFF, 5'd8, 1'b0, 1'b1, "R3");
    drive(32'hC0DE_1234, 5'd13, 1'b0, 1'b1, "R3");
    // R4: left shift
    drive(32'h0000_0001, 5'd31, 1'b1, 1'b0, "R4");
    drive(32'h1234_5678, 5'd7, 1'b1, 1'b0, "R4");
    drive(32'hFFFF_FFFF, 5'd3, 1'b1, 1'b0, "R4");
    // R5: arith must not change a left shift
    drive(32'h8765_4321, 5'd5, 1'b1, 1'b1, "R5");
    drive(32'hFFFF_0000, 5'd20, 1'b1, 1'b1, "R5");
    // R6: maximum amount in each mode
    drive(32'h8000_0000, 5'd31, 1'b0, 1'b0, "R6");
    drive(32'h8000_0000, 5'd31, 1'b0, 1'b1, "R6");
    drive(32'h4000_0000, 5'd31, 1'b0, 1'b1, "R6");
    drive(32'h0000_0003, 5'd31, 1'b1, 1'b0, "R6");
    // R8: each single stage alone, both directions
    for (int k = 0; k < 5; k++) begin
      drive(32'h9ABC_DEF1, 5'(1 << k), 1'b0, 1'b1, "R8");
      drive(32'h9ABC_DEF1, 5'(1 << k), 1'b1, 1'b0, "R8");
    end
    // R7: back-to-back changes every cycle, pseudo-random sweep
    lfsr = 32'hACE1_2468;
    for (int n = 0; n < 600; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      drive(lfsr ^ (lfsr << 13), lfsr[4:0], lfsr[7], lfsr[9], "R7");
    end
    while (sb_q.size() > 0) @(posedge clk);
    @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule